// File: doc/BRIEF.md
# Decentralized Daisy-Chain Bus Arbiter

This block grants a reconfigurable snooping bus to one node at a time without a central arbiter. Each node owns a small state machine that shares two wired-OR lines with its peers. The first is a request line, which a node drives while it wants the bus. The second is a busy line, which the current owner drives while it holds the bus. A grant token runs down a chain through the member nodes. A waiting node breaks the chain below itself, and a node that is not waiting passes the token on unchanged.

The chain is a ring whose entry point is the configured head node. The head's grant input is tied high, and the other positions follow in ascending index order with wrap-around. A per-node membership mask selects which nodes are attached to the current bus shape. A node outside the mask never competes and only passes the token through.

A node must wait for the bus to be free before it joins a round. It keeps the bus until its transaction-done strobe. When it has been served, it stands aside until every other node waiting in that round has been served. Persistent requesters are therefore granted in ring order.

Top module: `snoop_chain_arbiter`

## Requirements
- R1: While rst_ni is low, and directly after it rises, grant_o, bus_busy_o and bus_req_o are all zero.
- R2: A member raising req_i on an idle bus, with no other requester, sees its grant_o bit high after the second rising edge that samples the request, and low after the first.
- R3: At most one bit of grant_o is high in any cycle.
- R4: When several members begin waiting in the same cycle, the first grant goes to the member nearest the head in ring order. Ring order visits index head_i, then head_i+1, and so on modulo NODES.
- R5: An owner keeps its grant_o bit high until a rising edge samples its done_i bit. The grant drops at that edge. bus_busy_o is high exactly while some grant_o bit is high.
- R6: A node whose member_i bit is low is never granted and never drives bus_req_o, whatever its req_i bit shows.
- R7: Members that hold req_i high continuously are granted round after round in ring order from the head, each exactly once per round.
- R8: While the bus is owned, a member that raises req_i and has not yet been served in the current round drives bus_req_o high. It is not granted until the owner releases the bus.
- R9: A member that drops req_i before being granted is not granted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| head_i | input | $clog2(NODES) | Index of the node that starts the grant ring |
| member_i | input | NODES | Nodes attached to the current bus shape |
| req_i | input | NODES | Per-node local bus request |
| done_i | input | NODES | Per-node transaction-complete strobe, used by the owner |
| grant_o | output | NODES | Per-node bus ownership |
| bus_busy_o | output | 1 | Wired-OR busy line |
| bus_req_o | output | 1 | Wired-OR request line |

## Verification
A request seen at one rising edge moves the node to waiting at that edge, and the node owns the bus after the next edge. A done strobe frees the bus at the edge that samples it. The next waiter then takes the bus one edge later, because busy is registered. Inputs are changed and outputs sampled on falling edges, so every expectation falls on a known edge count. The order checks poll for the next grant with a bound instead of assuming a fixed gap, because the ring wraps at a round boundary and adds one cycle there. Every head position is combined with every membership mask, and each combination runs for two persistent rounds.

// File: rtl/snoop_arb_pkg.sv
package snoop_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OWN  = 2'd2
  } node_st_e;
endpackage

// File: rtl/arb_node.sv
module arb_node
  import snoop_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic member_i,
  input  logic req_i,
  input  logic done_i,
  input  logic grant_in_i,
  input  logic bus_busy_i,
  input  logic bus_req_i,
  output logic hold_o,
  output logic own_o,
  output logic req_drv_o
);
  node_st_e st_q, st_d;
  logic served_q, served_d;
  logic want, blocked;

  assign want    = member_i & req_i;
  // a served node stands aside until the round drains
  assign blocked = served_q & (bus_req_i | bus_busy_i);

  always_comb begin
    st_d     = st_q;
    served_d = served_q;
    unique case (st_q)
      ST_IDLE: begin
        if (want && !bus_busy_i && !blocked) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!want)                           st_d = ST_IDLE;
        else if (grant_in_i && !bus_busy_i)  st_d = ST_OWN;
      end
      ST_OWN: begin
        if (done_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (st_q == ST_OWN && done_i)                      served_d = 1'b1;
    else if (served_q && !bus_req_i && !bus_busy_i)    served_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      served_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      served_q <= served_d;
    end
  end

  assign hold_o    = (st_q == ST_WAIT);
  assign own_o     = (st_q == ST_OWN);
  assign req_drv_o = hold_o | ((st_q == ST_IDLE) & want & ~served_q);

  assert_take_after_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(own_o) |-> $past(hold_o && grant_in_i && !bus_busy_i));

  assert_release_on_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(own_o) |-> $past(done_i));

  assert_nonmember_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !member_i |=> !hold_o);
endmodule

// File: rtl/grant_chain.sv
module grant_chain #(
  parameter int NODES = 4,
  parameter int IW    = 2
) (
  input  logic [IW-1:0]    head_i,
  input  logic [NODES-1:0] hold_i,
  output logic [NODES-1:0] grant_in_o
);
  // walk the ring from the head; a waiting node cuts the token below it
  always_comb begin
    logic g;
    g          = 1'b1;
    grant_in_o = '0;
    for (int p = 0; p < NODES; p++) begin
      int idx;
      idx = int'(head_i) + p;
      if (idx >= NODES) idx = idx - NODES;
      grant_in_o[idx] = g;
      g = g & ~hold_i[idx];
    end
  end
endmodule

// File: rtl/snoop_chain_arbiter.sv
module snoop_chain_arbiter #(
  parameter  int NODES = 4,
  localparam int IW    = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IW-1:0]    head_i,
  input  logic [NODES-1:0] member_i,
  input  logic [NODES-1:0] req_i,
  input  logic [NODES-1:0] done_i,
  output logic [NODES-1:0] grant_o,
  output logic             bus_busy_o,
  output logic             bus_req_o
);
  logic [NODES-1:0] hold, own, req_drv, gin;

  grant_chain #(.NODES(NODES), .IW(IW)) u_chain (
    .head_i    (head_i),
    .hold_i    (hold),
    .grant_in_o(gin)
  );

  for (genvar i = 0; i < NODES; i++) begin : g_node
    arb_node u_node (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .member_i  (member_i[i]),
      .req_i     (req_i[i]),
      .done_i    (done_i[i]),
      .grant_in_i(gin[i]),
      .bus_busy_i(bus_busy_o),
      .bus_req_i (bus_req_o),
      .hold_o    (hold[i]),
      .own_o     (own[i]),
      .req_drv_o (req_drv[i])
    );
  end

  // wired-OR shared lines
  assign bus_busy_o = |own;
  assign bus_req_o  = |req_drv;
  assign grant_o    = own;

  assert_single_owner_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
endmodule

// File: tb/snoop_chain_arbiter_bench.sv
module snoop_chain_arbiter_bench;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]   head = '0;
  logic [N-1:0] member = '0, req = '0, done = '0;
  logic [N-1:0] grant;
  logic busy, breq;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  snoop_chain_arbiter #(.NODES(N)) u_snoop_chain_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .head_i(head), .member_i(member),
    .req_i(req), .done_i(done), .grant_o(grant),
    .bus_busy_o(busy), .bus_req_o(breq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  // R3 mutual exclusion and R5 busy tracks ownership, every cycle
  always @(negedge clk) if (rst_n) begin
    chk("R3 owners", 32'($countones(grant) > 1), 32'd0);
    chk("R5 busy", 32'(busy), 32'(grant != 0));
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  task automatic wait_grant(output logic [N-1:0] got);
    got = '0;
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      if (grant != 0) begin got = grant; break; end
    end
  endtask

  task automatic latency(input int h, input int i);
    head = 2'(h); member = '1;
    @(negedge clk); req[i] = 1'b1;
    @(negedge clk);
    chk("R2 early", 32'(grant), 32'd0);
    chk("R8 req line", 32'(breq), 32'd1);
    @(negedge clk);
    chk("R2 grant", 32'(grant), 32'(1 << i));
    repeat (2) begin
      @(negedge clk);
      chk("R5 hold", 32'(grant), 32'(1 << i));
    end
    done[i] = 1'b1; req[i] = 1'b0;
    @(negedge clk);
    chk("R5 release", 32'(grant), 32'd0);
    done = '0;
    @(negedge clk);
  endtask

  task automatic rounds(input int h, input logic [N-1:0] mask);
    logic [N-1:0] got;
    head = 2'(h); member = mask; req = '1; done = '0;
    if (mask == 0) begin
      repeat (8) @(negedge clk);
      chk("R6 no grant", 32'(grant), 32'd0);
      chk("R6 no req", 32'(breq), 32'd0);
    end else begin
      for (int r = 0; r < 2; r++) begin
        for (int p = 0; p < N; p++) begin
          int idx;
          idx = (h + p) % N;
          if (mask[idx]) begin
            wait_grant(got);
            chk(r == 0 ? "R4 order" : "R7 rotation", 32'(got), 32'(1 << idx));
            @(negedge clk);
            done[idx] = 1'b1;
            @(negedge clk);
            done = '0;
            chk("R5 drop", 32'(grant), 32'd0);
          end
        end
      end
    end
    req = '0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 grant", 32'(grant), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 req", 32'(breq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after", 32'({grant, busy, breq}), 32'd0);

    for (int h = 0; h < N; h++)
      for (int i = 0; i < N; i++) latency(h, i);

    for (int h = 0; h < N; h++)
      for (int m = 0; m < (1 << N); m++) rounds(h, N'(m));

    // R8 and R9: a request during ownership is held off, then withdrawn
    head = 2'd0; member = '1;
    @(negedge clk); req[1] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 owner", 32'(grant), 32'h2);
    req[3] = 1'b1;
    @(negedge clk);
    chk("R8 pending", 32'(breq), 32'd1);
    chk("R8 held off", 32'(grant), 32'h2);
    req[3] = 1'b0;
    @(negedge clk);
    done[1] = 1'b1; req[1] = 1'b0;
    @(negedge clk);
    done = '0;
    repeat (6) @(negedge clk);
    chk("R9 withdrawn", 32'(grant), 32'd0);
    chk("R9 req line", 32'(breq), 32'd0);

    summary();
  end
endmodule